// File: doc/BRIEF.md
# I2C Byte-Level Slave Engine

This block is an I2C slave that handles exactly one byte at a time and stores nothing beyond the byte in flight. It watches SCL and SDA, which arrive already synchronized to the system clock. It recognizes Start and Stop conditions, shifts bytes in and out most significant bit first, and can compare a 7-bit address in hardware. It never acknowledges on its own. At every byte boundary it pulls SCL low and waits for a host to decide what happens next: ACK, NACK, or send a byte.

The host reaches the block only through a small register set with a single-cycle write strobe and a combinational read port. Six registers are used:

| Offset | Access | Contents |
|---|---|---|
| 0 | read/write | control: bit 0 enables the slave, bit 1 enables address compare |
| 1 | read/write | own address in bits 6:0 |
| 2 | write / read | write: the byte to transmit; read: the last received byte |
| 3 | write | command: bit 0 ACK, bit 1 NACK, bit 2 SEND |
| 4 | read / write-one-to-clear | status: flags in bits 3:0 (BYTE, START, STOP, NACK); bit 4 SCL is held; bit 5 the held byte is an address; bit 6 the direction bit of the last address |
| 5 | read/write | interrupt enable, one bit per flag in bits 3:0 |

The host can poll the status register or wait for the interrupt. Writes act on the clock edge where the strobe is sampled. There is no back-pressure on the register port.

Top module: `i2c_byte_slave`

## Requirements
- R1: After reset, SCL and SDA are both released, every status bit reads 0 and the interrupt is low.
- R2: A Start condition sets the START flag (status bit 1) and begins a fresh address byte, even in the middle of a byte. A Stop condition returns the block to listening. If it arrives while a transfer is active it also sets the STOP flag (status bit 2), and bits sent after it without a new Start are ignored.
- R3: After the 8th bit of an accepted received byte, the block holds SCL low, sets the BYTE flag (status bit 0) and the hold bit (status bit 4), and keeps SCL low until a command is written.
- R4: Command bit 0 (ACK) makes the block pull SDA low during the 9th clock; command bit 1 (NACK) leaves SDA released, and NACK wins if both bits are set. SDA takes its new value on the edge that samples the write, and SCL is released on the following edge.
- R5: When address compare is on (control bit 1) and bits 7:1 of the address byte differ from the own address, the block does not stretch, does not set BYTE, leaves the 9th bit as NACK, and ignores everything until the next Start.
- R6: When address compare is off, the address byte is handed to the host like any data byte. It is readable at offset 2, and status bit 5 is set while that byte is held.
- R7: If bit 0 of an ACKed address byte is 1, then at the end of the ACK clock the block holds SCL, sets BYTE and reports status bit 6 = 1. It waits for command bit 2 (SEND), then shifts out the byte last written to offset 2, MSB first.
- R8: A master ACK after a transmitted byte makes the block hold SCL again and set BYTE. A master NACK sets the NACK flag (status bit 3), releases both lines and parks the block until a Stop or Start.
- R9: Flags stay set until the host writes 1 to the matching bit of offset 4; bits written as 0 are untouched. The interrupt is the OR of the flags that are enabled at offset 5.
- R10: Received bytes are assembled MSB first, and offset 2 returns the last byte received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| scl_i | input | 1 | synchronized SCL bus level |
| sda_i | input | 1 | synchronized SDA bus level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 3 | register offset |
| reg_wdata_i | input | BYTE_W | register write data |
| reg_rdata_o | output | BYTE_W | register read data |
| irq_o | output | 1 | interrupt request |

## Verification
The assertions assume the following about the bus:
- SCL stays low for many system clocks after each falling edge.
- SDA changes while SCL is high only to form a Start or a Stop.
- The lines seen by the block are the wired AND of the master and the block's own pull-downs.

The bench master respects all three. It moves SDA only while SCL is low, spends ten system clocks in each bus phase, and waits for SCL to read high before it continues, so it obeys stretching. The host side of the bench writes a command only while the block is holding SCL.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int REG_AW = 3;
  localparam int NFLAG  = 4;

  localparam int FL_BYTE  = 0;
  localparam int FL_START = 1;
  localparam int FL_STOP  = 2;
  localparam int FL_NACK  = 3;

  localparam logic [REG_AW-1:0] RG_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RG_OWN  = 3'd1;
  localparam logic [REG_AW-1:0] RG_DATA = 3'd2;
  localparam logic [REG_AW-1:0] RG_CMD  = 3'd3;
  localparam logic [REG_AW-1:0] RG_STAT = 3'd4;
  localparam logic [REG_AW-1:0] RG_IEN  = 3'd5;

  localparam int CMD_ACK  = 0;
  localparam int CMD_NACK = 1;
  localparam int CMD_SEND = 2;

  typedef enum logic [2:0] {
    ST_LISTEN, ST_RX, ST_RX_HOLD, ST_RX_ACK,
    ST_TX_HOLD, ST_TX, ST_TX_ACK, ST_PARK
  } eng_st_t;
endpackage

// File: rtl/i2cs_edge.sv
module i2cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edge while SCL stays high frames a transfer
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              cmp_en_i,
  input  logic [BYTE_W-2:0] own_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              cmd_ack_i,
  input  logic              cmd_nack_i,
  input  logic              cmd_send_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              ev_byte_o,
  output logic              ev_start_o,
  output logic              ev_stop_o,
  output logic              ev_nack_o,
  output logic              hold_o,
  output logic              addr_hold_o,
  output logic              dir_tx_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  eng_st_t           st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ack_q, mack_q, is_addr, setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_LISTEN; sh <= '0; cnt <= '0;
      ack_q <= 1'b0; mack_q <= 1'b0; is_addr <= 1'b0; setup_q <= 1'b0;
      rx_byte_o <= '0; dir_tx_o <= 1'b0;
      ev_byte_o <= 1'b0; ev_start_o <= 1'b0; ev_stop_o <= 1'b0; ev_nack_o <= 1'b0;
    end else begin
      ev_byte_o <= 1'b0; ev_start_o <= 1'b0; ev_stop_o <= 1'b0; ev_nack_o <= 1'b0;
      setup_q <= 1'b0;
      if (!en_i) begin
        st <= ST_LISTEN;
      end else if (start_i) begin
        st <= ST_RX; cnt <= '0; is_addr <= 1'b1; dir_tx_o <= 1'b0; ev_start_o <= 1'b1;
      end else if (stop_i) begin
        if (st != ST_LISTEN) ev_stop_o <= 1'b1;
        st <= ST_LISTEN;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + CNT_ONE;
            end else if (scl_fall_i && cnt == CNT_FULL) begin
              if (is_addr && cmp_en_i && sh[BYTE_W-1:1] != own_i) begin
                st <= ST_LISTEN;
              end else begin
                rx_byte_o <= sh;
                if (is_addr) dir_tx_o <= sh[0];
                st <= ST_RX_HOLD;
                ev_byte_o <= 1'b1;
              end
            end
          end
          ST_RX_HOLD: if (cmd_ack_i || cmd_nack_i) begin
            ack_q <= cmd_ack_i & ~cmd_nack_i;
            st <= ST_RX_ACK;
            setup_q <= 1'b1;
          end
          ST_RX_ACK: if (scl_fall_i) begin
            if (!ack_q) st <= ST_PARK;
            else if (is_addr && dir_tx_o) begin st <= ST_TX_HOLD; ev_byte_o <= 1'b1; end
            else begin st <= ST_RX; cnt <= '0; end
            is_addr <= 1'b0;
          end
          ST_TX_HOLD: if (cmd_send_i) begin
            sh <= tx_byte_i; cnt <= '0; st <= ST_TX; setup_q <= 1'b1;
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt == CNT_LAST) st <= ST_TX_ACK;
            else begin sh <= sh << 1; cnt <= cnt + CNT_ONE; end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) mack_q <= ~sda_i;
            else if (scl_fall_i) begin
              if (mack_q) begin st <= ST_TX_HOLD; ev_byte_o <= 1'b1; end
              else begin st <= ST_PARK; ev_nack_o <= 1'b1; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign hold_o      = (st == ST_RX_HOLD) || (st == ST_TX_HOLD);
  assign scl_oe_o    = hold_o || setup_q;
  assign sda_oe_o    = ((st == ST_RX_ACK) && ack_q) || ((st == ST_TX) && !sh[BYTE_W-1]);
  assign addr_hold_o = is_addr && (st == ST_RX_HOLD);

  // R3: no command, no release
  a_r3_hold_until_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i && !stop_i && st == ST_RX_HOLD && !cmd_ack_i && !cmd_nack_i) |=> scl_oe_o);
  // R4: own SDA moves only while SCL is low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_i || stop_i || !en_i)) |-> !scl_i);
  // R5: a mismatching address never stretches
  a_r5_no_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i && !stop_i && st == ST_RX && is_addr && cmp_en_i && scl_fall_i &&
     cnt == CNT_FULL && sh[BYTE_W-1:1] != own_i) |=> (!scl_oe_o && !sda_oe_o));
  // R8: master NACK frees both lines
  a_r8_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i && !stop_i && st == ST_TX_ACK && !scl_rise_i && scl_fall_i && !mack_q)
    |=> (!scl_oe_o && !sda_oe_o));
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              ev_byte_i,
  input  logic              ev_start_i,
  input  logic              ev_stop_i,
  input  logic              ev_nack_i,
  input  logic              hold_i,
  input  logic              addr_hold_i,
  input  logic              dir_tx_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              en_o,
  output logic              cmp_en_o,
  output logic [BYTE_W-2:0] own_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              cmd_ack_o,
  output logic              cmd_nack_o,
  output logic              cmd_send_o,
  output logic              irq_o
);
  logic [NFLAG-1:0] flags, ien, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[FL_BYTE]  = ev_byte_i;
    set_v[FL_START] = ev_start_i;
    set_v[FL_STOP]  = ev_stop_i;
    set_v[FL_NACK]  = ev_nack_i;
  end
  assign clr_v = (we_i && addr_i == RG_STAT) ? wdata_i[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= 1'b0; cmp_en_o <= 1'b0; own_o <= '0; tx_byte_o <= '0;
      flags <= '0; ien <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (we_i) begin
        case (addr_i)
          RG_CTRL: begin en_o <= wdata_i[0]; cmp_en_o <= wdata_i[1]; end
          RG_OWN:  own_o <= wdata_i[BYTE_W-2:0];
          RG_DATA: tx_byte_o <= wdata_i;
          RG_IEN:  ien <= wdata_i[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  assign cmd_ack_o  = we_i && addr_i == RG_CMD && wdata_i[CMD_ACK];
  assign cmd_nack_o = we_i && addr_i == RG_CMD && wdata_i[CMD_NACK];
  assign cmd_send_o = we_i && addr_i == RG_CMD && wdata_i[CMD_SEND];
  assign irq_o      = |(flags & ien);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RG_CTRL: rdata_o = BYTE_W'({cmp_en_o, en_o});
      RG_OWN:  rdata_o = BYTE_W'(own_o);
      RG_DATA: rdata_o = rx_byte_i;
      RG_STAT: rdata_o = BYTE_W'({dir_tx_i, addr_hold_i, hold_i, flags});
      RG_IEN:  rdata_o = BYTE_W'(ien);
      default: rdata_o = '0;
    endcase
  end

  // R9: a flag not cleared survives to the next cycle
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & $past(flags & ~clr_v)) == $past(flags & ~clr_v)));
endmodule

// File: rtl/i2c_byte_slave.sv
module i2c_byte_slave
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic scl_rise, scl_fall, start_c, stop_c;
  logic en, cmp_en, cmd_ack, cmd_nack, cmd_send;
  logic [BYTE_W-2:0] own;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic ev_byte, ev_start, ev_stop, ev_nack, hold, addr_hold, dir_tx;

  i2cs_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_c), .stop_o(stop_c)
  );

  i2cs_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en_i(en), .cmp_en_i(cmp_en), .own_i(own),
    .tx_byte_i(tx_byte), .cmd_ack_i(cmd_ack), .cmd_nack_i(cmd_nack), .cmd_send_i(cmd_send),
    .scl_i(scl_i), .sda_i(sda_i), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .rx_byte_o(rx_byte), .ev_byte_o(ev_byte), .ev_start_o(ev_start), .ev_stop_o(ev_stop),
    .ev_nack_o(ev_nack), .hold_o(hold), .addr_hold_o(addr_hold), .dir_tx_o(dir_tx)
  );

  i2cs_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ev_byte_i(ev_byte), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
    .ev_nack_i(ev_nack), .hold_i(hold), .addr_hold_i(addr_hold), .dir_tx_i(dir_tx),
    .rx_byte_i(rx_byte), .en_o(en), .cmp_en_o(cmp_en), .own_o(own), .tx_byte_o(tx_byte),
    .cmd_ack_o(cmd_ack), .cmd_nack_o(cmd_nack), .cmd_send_o(cmd_send), .irq_o(irq_o)
  );
endmodule

// File: tb/sim_i2c_byte_slave.sv
`timescale 1ns/1ps
module sim_i2c_byte_slave;
  import i2cs_pkg::*;

  localparam int HALF = 10;
  localparam logic [6:0] MYADR = 7'h5A;
  localparam int NVEC = 6;
  // {data byte, host ack}
  localparam logic [8:0] VEC [NVEC] = '{9'h001, 9'h1FF, 9'h14A, 9'h0B5, 9'h102, 9'h079};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl, sda;
  assign scl = scl_m & ~scl_oe;
  assign sda = sda_m & ~sda_oe;

  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  i2c_byte_slave #(.BYTE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_scl();
    while (!scl) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; wait_scl(); hw();
    sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; wait_scl(); hw(); sda_m = 1'b1; hw();
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; hw(); scl_m = 1'b1; wait_scl(); hw();
    r = sda; scl_m = 1'b0; hw();
  endtask

  task automatic m_wr8(input logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
  endtask

  task automatic m_rd8(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit(1'b1, v[i]);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic r;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl released", int'(scl_oe), 0);
    chk("R1 sda released", int'(sda_oe), 0);
    rd(RG_STAT, v); chk("R1 status clear", int'(v), 0);
    chk("R1 irq low", int'(irq), 0);

    wr(RG_OWN, {1'b0, MYADR});
    wr(RG_CTRL, 8'h03);

    // table walk: receive one byte per transaction
    for (int i = 0; i < NVEC; i++) begin
      wr(RG_STAT, 8'h0F);
      m_start(); m_wr8({MYADR, 1'b0});
      wr(RG_CMD, 8'h01); m_bit(1'b1, r);
      chk("R4 address acked", int'(r), 0);
      m_wr8(VEC[i][8:1]);
      rd(RG_DATA, v); chk("R10 received byte", int'(v), int'(VEC[i][8:1]));
      wr(RG_CMD, VEC[i][0] ? 8'h01 : 8'h02); m_bit(1'b1, r);
      chk("R4 data ack or nack", int'(r), int'(!VEC[i][0]));
      m_stop();
    end

    // R3/R4: stretch and release timing
    wr(RG_STAT, 8'h0F);
    m_start(); m_wr8({MYADR, 1'b0});
    repeat (40) @(negedge clk);
    chk("R3 scl held", int'(scl_oe), 1);
    chk("R3 bus scl low", int'(scl), 0);
    rd(RG_STAT, v); chk("R3 status at hold", int'(v), 8'h33);
    @(negedge clk); we = 1'b1; addr = RG_CMD; wdata = 8'h01;
    @(negedge clk); we = 1'b0;
    chk("R4 sda driven first", int'(sda_oe), 1);
    chk("R4 scl still held", int'(scl_oe), 1);
    @(negedge clk);
    chk("R4 scl released", int'(scl_oe), 0);
    m_bit(1'b1, r); chk("R4 ack seen", int'(r), 0);
    m_stop();
    rd(RG_STAT, v); chk("R2 stop flag", int'(v), 8'h07);

    // R2: restart in the middle of a byte
    wr(RG_STAT, 8'h0F);
    m_start(); m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
    wr(RG_STAT, 8'h0F);
    m_start();
    rd(RG_STAT, v); chk("R2 restart flag", int'(v), 8'h02);
    chk("R2 no hold after restart", int'(scl_oe), 0);
    m_wr8({MYADR, 1'b0});
    rd(RG_STAT, v); chk("R2 fresh address", int'(v), 8'h33);
    wr(RG_CMD, 8'h01); m_bit(1'b1, r); m_stop();

    // R2: stop in the middle of a byte, then bits without start
    wr(RG_STAT, 8'h0F);
    m_start(); m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b1, r);
    m_stop();
    rd(RG_STAT, v); chk("R2 stop mid-byte", int'(v), 8'h06);
    m_wr8({MYADR, 1'b0}); hw();
    chk("R2 listening no hold", int'(scl_oe), 0);
    rd(RG_STAT, v); chk("R2 listening no flag", int'(v), 8'h06);

    // R5: address mismatch
    wr(RG_STAT, 8'h0F);
    m_start(); m_wr8(8'h66); hw();
    chk("R5 no stretch", int'(scl_oe), 0);
    rd(RG_STAT, v); chk("R5 no byte flag", int'(v), 8'h02);
    m_bit(1'b1, r); chk("R5 nack on bus", int'(r), 1);
    m_wr8({MYADR, 1'b0}); m_bit(1'b1, r);
    chk("R5 ignored until start", int'(r), 1);
    m_stop();
    rd(RG_STAT, v); chk("R5 no stop flag", int'(v), 8'h02);

    // R6: compare disabled, address handed to host
    wr(RG_CTRL, 8'h01); wr(RG_STAT, 8'h0F);
    m_start(); m_wr8(8'h66);
    rd(RG_DATA, v); chk("R6 address as data", int'(v), 8'h66);
    rd(RG_STAT, v); chk("R6 address hold status", int'(v), 8'h33);
    wr(RG_CMD, 8'h02); m_bit(1'b1, r); chk("R4 nack leaves sda", int'(r), 1);
    m_stop();
    rd(RG_STAT, v); chk("R6 parked then stop", int'(v), 8'h07);
    wr(RG_CTRL, 8'h03);

    // R7/R8: transmit path
    wr(RG_STAT, 8'h0F);
    m_start(); m_wr8({MYADR, 1'b1});
    wr(RG_CMD, 8'h01); m_bit(1'b1, r); chk("R7 read address acked", int'(r), 0);
    hw();
    chk("R7 scl held for send", int'(scl_oe), 1);
    rd(RG_STAT, v); chk("R7 tx hold status", int'(v), 8'h53);
    wr(RG_DATA, 8'hA5); wr(RG_CMD, 8'h04);
    m_rd8(v); chk("R7 first tx byte", int'(v), 8'hA5);
    wr(RG_STAT, 8'h0F);
    m_bit(1'b0, r); hw();
    rd(RG_STAT, v); chk("R8 master ack holds", int'(v), 8'h51);
    wr(RG_STAT, 8'h0F);
    wr(RG_DATA, 8'h3C); wr(RG_CMD, 8'h04);
    m_rd8(v); chk("R7 second tx byte", int'(v), 8'h3C);
    m_bit(1'b1, r); hw();
    rd(RG_STAT, v); chk("R8 nack flag", int'(v), 8'h48);
    chk("R8 sda released", int'(sda_oe), 0);
    chk("R8 scl released", int'(scl_oe), 0);
    m_stop();
    rd(RG_STAT, v); chk("R8 stop after nack", int'(v), 8'h4C);

    // R9: interrupt masking and write-one-to-clear
    wr(RG_STAT, 8'h0F); wr(RG_IEN, 8'h04);
    m_start(); m_wr8({MYADR, 1'b0});
    chk("R9 masked flags no irq", int'(irq), 0);
    wr(RG_CMD, 8'h01); m_bit(1'b1, r); m_stop();
    chk("R9 stop raises irq", int'(irq), 1);
    wr(RG_STAT, 8'h04);
    chk("R9 irq cleared", int'(irq), 0);
    rd(RG_STAT, v); chk("R9 other flags kept", int'(v), 8'h03);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule